// File: doc/BRIEF.md
# Double-Buffered Parallel Converter Register Interface

This block is the digital front end of a 16-bit converter with a parallel bus. A host writes a word into a staging register during a chip-select cycle and can read the same word back to verify it. A separate load strobe then moves the staged word into the output register that feeds the converter code. Because of this, the analog output only changes when the host asks it to.

A dedicated active-low reset pin forces the output register to either the minimum code or the mid-scale code, chosen by a select pin. This reset leaves the staging register untouched. Every pin is asynchronous to the system clock. Each pin passes through a two-flop synchroniser, and the chip-select and load edges are detected on the synchronised copies.

The tri-state data bus is split into `data_i`, `data_o` and `data_oe_o`, so the pad can implement the high-impedance state.

Top module: `dac_par_if`

## Requirements
- R1: After system reset `rst_ni`, `code_o` is 16'h0000 and `data_oe_o` is 0.
- R2: A write cycle has `cs_ni` low and `rw_i` low, with `data_i` held stable. At the rising edge of `cs_ni` that ends the cycle, the staging register takes the `data_i` value.
- R3: `data_oe_o` is 1 exactly while the synchronised `cs_ni` is 0 and the synchronised `rw_i` is 1. The enable rises on the second clock edge after the pins settle, and it falls on the second clock edge after `cs_ni` rises. While the enable is 1, `data_o` returns the staging register.
- R4: While `data_oe_o` is 0, `data_o` is 16'h0000. `data_oe_o` is 0 whenever `cs_ni` has been high for two clock edges.
- R5: A write cycle never changes `code_o`.
- R6: A rising edge of `ld_i` copies the staging register to `code_o`. A falling edge of `ld_i`, or holding it high, has no further effect.
- R7: While `dac_rst_ni` is low and `rst_sel_i` is 1, `code_o` is 16'h8000 (only the top bit set).
- R8: While `dac_rst_ni` is low and `rst_sel_i` is 0, `code_o` is 16'h0000.
- R9: `dac_rst_ni` does not alter the staging register, so a read after it returns the last written word.
- R10: A rising edge of `ld_i` while `dac_rst_ni` is low is ignored. After `dac_rst_ni` is released, the reset code stays until the next rising edge of `ld_i`.
- R11: A read cycle (`cs_ni` rising with `rw_i` high) leaves the staging register unchanged, whatever is on `data_i`.
- R12: `code_o` takes its new value on the third rising clock edge after `ld_i` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous system reset, active low |
| cs_ni | input | 1 | Chip select pin, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| data_i | input | 16 | Bus value from the pad |
| data_o | output | 16 | Readback value to the pad |
| data_oe_o | output | 1 | Pad output enable |
| ld_i | input | 1 | Load strobe, rising edge active |
| dac_rst_ni | input | 1 | Output register reset pin, active low |
| rst_sel_i | input | 1 | Reset target: 1 = mid-scale, 0 = minimum |
| code_o | output | 16 | Converter code |

## Verification
The bench builds the block with its default 16-bit width and two synchroniser stages. With two stages, the enable and load latencies are short, fixed edge counts that the bench samples exactly.

At 16 bits, mid-scale is the lone top bit. The bench also uses all-ones and alternating words to expose any dropped or swapped bit between the bus, the staging register and the code. Both reset targets are exercised, together with a load pulse while reset is held.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  // synchronised control pins, packed for one synchroniser instance
  typedef struct packed {
    logic cs_n;
    logic rw;
    logic ld;
    logic rst_n;
    logic sel;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);
  // idle pin levels: deselected, read, strobe high (no false edge), reset released
  localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, rw: 1'b1, ld: 1'b1, rst_n: 1'b1, sel: 1'b0};
endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dac_edge_det.sv
module dac_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic ld_i,
  output logic cs_rise_o,
  output logic ld_rise_o
);
  logic cs_prev_q, ld_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q <= 1'b1;
      ld_prev_q <= 1'b1;
    end else begin
      cs_prev_q <= cs_n_i;
      ld_prev_q <= ld_i;
    end
  end

  assign cs_rise_o = cs_n_i & ~cs_prev_q;
  assign ld_rise_o = ld_i & ~ld_prev_q;
endmodule

// File: rtl/dac_in_reg.sv
module dac_in_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_rise_i,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] in_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_q_o <= '0;
    else if (cs_rise_i && !rw_i) in_q_o <= data_i;
  end
endmodule

// File: rtl/dac_out_reg.sv
module dac_out_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_rise_i,
  input  logic              dac_rst_n_i,
  input  logic              sel_mid_i,
  input  logic [DATA_W-1:0] in_q_i,
  output logic [DATA_W-1:0] code_o
);
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MIN_CODE = '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_o <= MIN_CODE;
    else if (!dac_rst_n_i) code_o <= sel_mid_i ? MID_CODE : MIN_CODE;
    else if (ld_rise_i) code_o <= in_q_i;
  end
endmodule

// File: rtl/dac_par_if.sv
module dac_par_if
  import dac_if_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic              ld_i,
  input  logic              dac_rst_ni,
  input  logic              rst_sel_i,
  output logic [DATA_W-1:0] code_o
);
  ctl_t              pin_ctl, s_ctl;
  logic [CTL_W-1:0]  s_ctl_raw;
  logic [DATA_W-1:0] s_data;
  logic              cs_rise, ld_rise;
  logic [DATA_W-1:0] in_q;

  always_comb begin
    pin_ctl.cs_n  = cs_ni;
    pin_ctl.rw    = rw_i;
    pin_ctl.ld    = ld_i;
    pin_ctl.rst_n = dac_rst_ni;
    pin_ctl.sel   = rst_sel_i;
  end

  dac_pin_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_ctl), .q_o(s_ctl_raw)
  );
  assign s_ctl = ctl_t'(s_ctl_raw);

  // bus synchronised with the same depth so it lines up with the CS edge
  dac_pin_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(data_i), .q_o(s_data)
  );

  dac_edge_det u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(s_ctl.cs_n), .ld_i(s_ctl.ld),
    .cs_rise_o(cs_rise), .ld_rise_o(ld_rise)
  );

  dac_in_reg #(.DATA_W(DATA_W)) u_in_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_rise_i(cs_rise), .rw_i(s_ctl.rw),
    .data_i(s_data), .in_q_o(in_q)
  );

  dac_out_reg #(.DATA_W(DATA_W)) u_out_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_rise_i(ld_rise), .dac_rst_n_i(s_ctl.rst_n),
    .sel_mid_i(s_ctl.sel), .in_q_i(in_q), .code_o(code_o)
  );

  assign data_oe_o = ~s_ctl.cs_n & s_ctl.rw;
  assign data_o    = data_oe_o ? in_q : '0;
endmodule

// File: rtl/dac_par_if_chk.sv
module dac_par_if_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rw_i,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] code_o,
  input logic [DATA_W-1:0] in_q,
  input logic              cs_rise,
  input logic              ld_rise,
  input logic              s_rw,
  input logic              s_rst_n,
  input logic              s_sel
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  // depth 2 matches the default synchroniser depth
  assert_oe_from_pins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!$past(cs_ni, 2) && $past(rw_i, 2)));

  assert_code_moves_only_on_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> ($past(ld_rise) || !$past(s_rst_n)));

  assert_load_copies_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ld_rise && s_rst_n) |-> code_o == $past(in_q));

  assert_rst_mid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!s_rst_n && s_sel) |-> code_o == MID);

  assert_rst_min_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!s_rst_n && !s_sel) |-> code_o == '0);

  assert_read_keeps_stage_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_rise && s_rw) |-> $stable(in_q));
endmodule

bind dac_par_if dac_par_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rw_i(rw_i),
  .data_oe_o(data_oe_o), .code_o(code_o), .in_q(in_q),
  .cs_rise(cs_rise), .ld_rise(ld_rise), .s_rw(s_ctl.rw),
  .s_rst_n(s_ctl.rst_n), .s_sel(s_ctl.sel)
);

// File: tb/tb_dac_par_if.sv
module tb_dac_par_if;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rw = 1'b1, ld = 1'b0, dac_rst_n = 1'b1, sel = 1'b0;
  logic [15:0] din = '0, dout, code;
  logic oe;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  dac_par_if dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rw_i(rw), .data_i(din),
    .data_o(dout), .data_oe_o(oe), .ld_i(ld), .dac_rst_ni(dac_rst_n),
    .rst_sel_i(sel), .code_o(code)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] w);
    nclk(1); rw = 1'b0; din = w; cs_n = 1'b0;
    nclk(3); cs_n = 1'b1;
    nclk(4); rw = 1'b1; din = 16'hDEAD;
  endtask

  task automatic do_read(input logic [15:0] exp, input string tag);
    nclk(1); rw = 1'b1; din = 16'hFFFF; cs_n = 1'b0;
    nclk(3);
    chk(oe == 1'b1, tag, {15'd0, oe}, 16'd1);
    chk(dout == exp, tag, dout, exp);
    cs_n = 1'b1;
    nclk(3);
    chk(oe == 1'b0 && dout == 16'h0, "R4", dout, 16'h0);
  endtask

  task automatic do_load();
    nclk(1); ld = 1'b1; nclk(4); ld = 1'b0; nclk(4);
  endtask

  task automatic t_reset_state();
    chk(code == 16'h0000, "R1", code, 16'h0000);
    chk(oe == 1'b0, "R1", {15'd0, oe}, 16'd0);
    chk(dout == 16'h0, "R4", dout, 16'h0);
  endtask

  task automatic t_write_read();
    do_write(16'hA5C3);
    chk(code == 16'h0000, "R5", code, 16'h0000);
    do_read(16'hA5C3, "R2");
  endtask

  task automatic t_load_latency();
    nclk(1); ld = 1'b1;
    nclk(2); chk(code == 16'h0000, "R12", code, 16'h0000);
    nclk(1); chk(code == 16'hA5C3, "R12", code, 16'hA5C3);
    nclk(3); chk(code == 16'hA5C3, "R6", code, 16'hA5C3);
    ld = 1'b0; nclk(4);
    chk(code == 16'hA5C3, "R6", code, 16'hA5C3);
    do_write(16'h1234);
    chk(code == 16'hA5C3, "R5", code, 16'hA5C3);
    do_load();
    chk(code == 16'h1234, "R6", code, 16'h1234);
  endtask

  task automatic t_read_no_modify();
    do_read(16'h1234, "R11");
    do_read(16'h1234, "R11");
  endtask

  task automatic t_oe_timing();
    nclk(1); rw = 1'b1; cs_n = 1'b0;
    @(posedge clk); #1 chk(oe == 1'b0, "R3", {15'd0, oe}, 16'd0);
    @(posedge clk); #1 chk(oe == 1'b1, "R3", {15'd0, oe}, 16'd1);
    nclk(1); cs_n = 1'b1;
    @(posedge clk); #1 chk(oe == 1'b1, "R3", {15'd0, oe}, 16'd1);
    @(posedge clk); #1 chk(oe == 1'b0, "R3", {15'd0, oe}, 16'd0);
    chk(dout == 16'h0, "R4", dout, 16'h0);
  endtask

  task automatic t_rst_mid();
    nclk(1); sel = 1'b1; nclk(3); dac_rst_n = 1'b0; nclk(4);
    chk(code == 16'h8000, "R7", code, 16'h8000);
    do_load();
    chk(code == 16'h8000, "R10", code, 16'h8000);
    dac_rst_n = 1'b1; nclk(4);
    chk(code == 16'h8000, "R10", code, 16'h8000);
    sel = 1'b0;
    do_read(16'h1234, "R9");
    do_load();
    chk(code == 16'h1234, "R6", code, 16'h1234);
  endtask

  task automatic t_rst_min();
    do_write(16'hFFFF);
    do_load();
    chk(code == 16'hFFFF, "R6", code, 16'hFFFF);
    nclk(1); sel = 1'b0; nclk(3); dac_rst_n = 1'b0; nclk(4);
    chk(code == 16'h0000, "R8", code, 16'h0000);
    dac_rst_n = 1'b1; nclk(4);
    do_read(16'hFFFF, "R9");
    do_write(16'h5AA5);
    chk(code == 16'h0000, "R5", code, 16'h0000);
    do_load();
    chk(code == 16'h5AA5, "R6", code, 16'h5AA5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    nclk(4); rst_n = 1'b1; nclk(4);
    t_reset_state();
    t_write_read();
    t_load_latency();
    t_read_no_modify();
    t_oe_timing();
    t_rst_mid();
    t_rst_min();
    nclk(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule